// File: doc/BRIEF.md
# FIFO Threshold Interrupt Controller

This block holds the transmit and receive data queues of a serial controller and turns their fill state into interrupts. The bus side writes frames into the transmit queue and reads frames from the receive queue. The serial side takes frames from the transmit queue and deposits received frames into the receive queue. Both queues have the same parameterised depth, which can be 2 to 256 entries, and each reports its current fill level.

Two programmable thresholds drive two level-based interrupts. One fires when the transmit queue needs refilling. The other fires when the receive queue holds enough data to be drained. Three error conditions are latched as sticky flags: a write into a full transmit queue, a push into a full receive queue, and a read from an empty receive queue. A threshold write is kept only when the value is below the depth, so software can find the depth by writing values and reading them back. A mask selects which raw sources reach the single interrupt line. Dropping the global enable empties both queues.

Top module: `fifo_irq_ctrl`

## Requirements
- R1: After reset both levels and both thresholds are 0, all error flags are clear, and the raw status is 5'b00001.
- R2: The transmit level rises by one for each accepted bus write and falls by one for each accepted serial pop. The receive level rises for each accepted serial push and falls for each accepted bus read. Each level stays between 0 and the depth.
- R3: Both queues deliver frames in the order they were accepted. The head frame is visible on the read data output before it is removed.
- R4: A threshold write with a value below the depth is stored. A write with a value at or above the depth leaves the register unchanged.
- R5: Raw bit 0 (transmit needs data) is 1 exactly when the transmit level is at or below the transmit threshold.
- R6: Raw bit 4 (receive ready) is 1 exactly when the receive level is at least the receive threshold plus one.
- R7: A bus write while the transmit queue is full sets raw bit 1 and drops the frame. A serial pop in the same cycle still removes one frame.
- R8: A serial push while the receive queue is full, judged on the level at the start of the cycle, sets raw bit 3 and drops the frame.
- R9: A bus read while the receive queue is empty sets raw bit 2 and does not change the level.
- R10: Raw bits 1, 2 and 3 stay set until a clear pulse. When a new error occurs in the same cycle as a clear, the new error stays set.
- R11: The masked status equals raw AND mask, and the interrupt line is the OR of the masked bits.
- R12: While the global enable is low, both queues are empty from the next cycle on, all data accesses are ignored and raise no error, and the thresholds keep their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| en_i | input | 1 | Global enable; low flushes both queues |
| bus_wr_i | input | 1 | Bus write strobe into the transmit queue |
| bus_wdata_i | input | DW | Bus write data |
| bus_rd_i | input | 1 | Bus read strobe from the receive queue |
| bus_rdata_o | output | DW | Head frame of the receive queue |
| ser_pop_i | input | 1 | Serial side takes a frame from the transmit queue |
| ser_tx_data_o | output | DW | Head frame of the transmit queue |
| ser_tx_valid_o | output | 1 | Transmit queue not empty |
| ser_push_i | input | 1 | Serial side delivers a received frame |
| ser_rx_data_i | input | DW | Received frame |
| tx_thr_wr_i | input | 1 | Write strobe for the transmit threshold |
| rx_thr_wr_i | input | 1 | Write strobe for the receive threshold |
| thr_wdata_i | input | TW | Threshold write value |
| tx_thr_o | output | TW | Transmit threshold |
| rx_thr_o | output | TW | Receive threshold |
| irq_mask_i | input | 5 | Interrupt mask, one bit per raw source |
| err_clr_i | input | 1 | Clears the three sticky error flags |
| tx_level_o | output | LW | Transmit fill level |
| rx_level_o | output | LW | Receive fill level |
| raw_irq_o | output | 5 | Raw status: bit4 rx ready, bit3 rx overflow, bit2 rx underflow, bit1 tx overflow, bit0 tx needs data |
| masked_irq_o | output | 5 | Masked status |
| irq_o | output | 1 | Combined interrupt |

## Verification
Two things can land in the same cycle: a sticky-flag clear and a new error of the same kind. The bench provokes this with a bus read of the empty receive queue in the same cycle as a clear pulse. It expects the underflow bit to survive while the other error bits fall. A second collision is a bus write into a full transmit queue while the serial side pops. Here the bench expects the overflow flag together with a level that is one lower, which shows that fullness is judged before the pop. A third is a serial push into a full receive queue, where the bench expects the frame to be dropped and the overflow flag to be set.

// File: rtl/fifo_irq_pkg.sv
package fifo_irq_pkg;
  localparam int IRQ_N   = 5;
  localparam int IDX_TXE = 0;
  localparam int IDX_TXO = 1;
  localparam int IDX_RXU = 2;
  localparam int IDX_RXO = 3;
  localparam int IDX_RXF = 4;
  typedef logic [IRQ_N-1:0] irq_vec_t;
endpackage

// File: rtl/fifo_irq_buf.sv
module fifo_irq_buf #(
  parameter int DEPTH = 8,
  parameter int DW    = 8,
  localparam int AW   = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int LW   = $clog2(DEPTH + 1)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          flush_i,
  input  logic          push_i,
  input  logic [DW-1:0] wdata_i,
  input  logic          pop_i,
  output logic [DW-1:0] rdata_o,
  output logic [LW-1:0] level_o,
  output logic          full_o,
  output logic          empty_o
);
  logic [DW-1:0] mem_q [DEPTH];
  logic [AW-1:0] wptr_q, rptr_q;
  logic [LW-1:0] lvl_q;
  logic          push_ok, pop_ok;

  function automatic logic [AW-1:0] ptr_inc(input logic [AW-1:0] p);
    return (p == AW'(DEPTH - 1)) ? '0 : p + AW'(1);
  endfunction

  assign full_o  = (lvl_q == LW'(DEPTH));
  assign empty_o = (lvl_q == '0);
  assign push_ok = push_i & ~full_o;
  assign pop_ok  = pop_i & ~empty_o;
  assign level_o = lvl_q;
  assign rdata_o = mem_q[rptr_q];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wptr_q <= '0;
      rptr_q <= '0;
      lvl_q  <= '0;
    end else if (flush_i) begin
      wptr_q <= '0;
      rptr_q <= '0;
      lvl_q  <= '0;
    end else begin
      if (push_ok) wptr_q <= ptr_inc(wptr_q);
      if (pop_ok)  rptr_q <= ptr_inc(rptr_q);
      lvl_q <= lvl_q + LW'(push_ok) - LW'(pop_ok);
    end
  end

  always_ff @(posedge clk_i) begin
    if (push_ok && !flush_i) mem_q[wptr_q] <= wdata_i;
  end
endmodule

// File: rtl/fifo_irq_thr.sv
module fifo_irq_thr #(
  parameter int DEPTH = 8,
  parameter int TW    = 8
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          wr_i,
  input  logic [TW-1:0] wdata_i,
  output logic [TW-1:0] thr_o
);
  // out-of-range values are rejected so the depth can be probed
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                              thr_o <= '0;
    else if (wr_i && (int'(wdata_i) < DEPTH)) thr_o <= wdata_i;
  end
endmodule

// File: rtl/fifo_irq_stat.sv
module fifo_irq_stat
  import fifo_irq_pkg::*;
#(
  parameter int DEPTH = 8,
  parameter int TW    = 8,
  localparam int LW   = $clog2(DEPTH + 1)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic [LW-1:0] tx_level_i,
  input  logic [LW-1:0] rx_level_i,
  input  logic [TW-1:0] tx_thr_i,
  input  logic [TW-1:0] rx_thr_i,
  input  logic          tx_over_ev_i,
  input  logic          rx_over_ev_i,
  input  logic          rx_under_ev_i,
  input  logic          clr_i,
  input  irq_vec_t      mask_i,
  output irq_vec_t      raw_o,
  output irq_vec_t      masked_o,
  output logic          irq_o
);
  localparam int NERR = 3;
  localparam int ERR_IDX [NERR] = '{IDX_TXO, IDX_RXU, IDX_RXO};

  logic [NERR-1:0] ev, err_q;
  assign ev = {rx_over_ev_i, rx_under_ev_i, tx_over_ev_i};

  for (genvar k = 0; k < NERR; k++) begin : g_err
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) err_q[k] <= 1'b0;
      else         err_q[k] <= ev[k] | (err_q[k] & ~clr_i);
    end
    assign raw_o[ERR_IDX[k]] = err_q[k];
  end

  assign raw_o[IDX_TXE] = int'(tx_level_i) <= int'(tx_thr_i);
  assign raw_o[IDX_RXF] = int'(rx_level_i) >= int'(rx_thr_i) + 1;
  assign masked_o       = raw_o & mask_i;
  assign irq_o          = |masked_o;
endmodule

// File: rtl/fifo_irq_ctrl.sv
module fifo_irq_ctrl
  import fifo_irq_pkg::*;
#(
  parameter int DEPTH = 8,
  parameter int DW    = 8,
  parameter int TW    = 8,
  localparam int LW   = $clog2(DEPTH + 1)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             en_i,
  input  logic             bus_wr_i,
  input  logic [DW-1:0]    bus_wdata_i,
  input  logic             bus_rd_i,
  output logic [DW-1:0]    bus_rdata_o,
  input  logic             ser_pop_i,
  output logic [DW-1:0]    ser_tx_data_o,
  output logic             ser_tx_valid_o,
  input  logic             ser_push_i,
  input  logic [DW-1:0]    ser_rx_data_i,
  input  logic             tx_thr_wr_i,
  input  logic             rx_thr_wr_i,
  input  logic [TW-1:0]    thr_wdata_i,
  output logic [TW-1:0]    tx_thr_o,
  output logic [TW-1:0]    rx_thr_o,
  input  logic [IRQ_N-1:0] irq_mask_i,
  input  logic             err_clr_i,
  output logic [LW-1:0]    tx_level_o,
  output logic [LW-1:0]    rx_level_o,
  output logic [IRQ_N-1:0] raw_irq_o,
  output logic [IRQ_N-1:0] masked_irq_o,
  output logic             irq_o
);
  logic flush;
  logic tx_full, tx_empty, rx_full, rx_empty;

  assign flush = ~en_i;

  fifo_irq_buf #(.DEPTH(DEPTH), .DW(DW)) u_tx_buf (
    .clk_i, .rst_ni, .flush_i(flush),
    .push_i(en_i & bus_wr_i), .wdata_i(bus_wdata_i),
    .pop_i(en_i & ser_pop_i), .rdata_o(ser_tx_data_o),
    .level_o(tx_level_o), .full_o(tx_full), .empty_o(tx_empty)
  );

  fifo_irq_buf #(.DEPTH(DEPTH), .DW(DW)) u_rx_buf (
    .clk_i, .rst_ni, .flush_i(flush),
    .push_i(en_i & ser_push_i), .wdata_i(ser_rx_data_i),
    .pop_i(en_i & bus_rd_i), .rdata_o(bus_rdata_o),
    .level_o(rx_level_o), .full_o(rx_full), .empty_o(rx_empty)
  );

  assign ser_tx_valid_o = ~tx_empty;

  fifo_irq_thr #(.DEPTH(DEPTH), .TW(TW)) u_tx_thr (
    .clk_i, .rst_ni, .wr_i(tx_thr_wr_i), .wdata_i(thr_wdata_i), .thr_o(tx_thr_o)
  );
  fifo_irq_thr #(.DEPTH(DEPTH), .TW(TW)) u_rx_thr (
    .clk_i, .rst_ni, .wr_i(rx_thr_wr_i), .wdata_i(thr_wdata_i), .thr_o(rx_thr_o)
  );

  fifo_irq_stat #(.DEPTH(DEPTH), .TW(TW)) u_stat (
    .clk_i, .rst_ni,
    .tx_level_i(tx_level_o), .rx_level_i(rx_level_o),
    .tx_thr_i(tx_thr_o), .rx_thr_i(rx_thr_o),
    .tx_over_ev_i(en_i & bus_wr_i & tx_full),
    .rx_over_ev_i(en_i & ser_push_i & rx_full),
    .rx_under_ev_i(en_i & bus_rd_i & rx_empty),
    .clr_i(err_clr_i), .mask_i(irq_mask_i),
    .raw_o(raw_irq_o), .masked_o(masked_irq_o), .irq_o(irq_o)
  );
endmodule

// File: rtl/fifo_irq_ctrl_chk.sv
module fifo_irq_ctrl_chk #(
  parameter int DEPTH = 8,
  parameter int TW    = 8,
  localparam int LW   = $clog2(DEPTH + 1)
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic          en_i,
  input logic          bus_wr_i,
  input logic          bus_rd_i,
  input logic          ser_pop_i,
  input logic          ser_push_i,
  input logic          err_clr_i,
  input logic [TW-1:0] tx_thr_o,
  input logic [LW-1:0] tx_level_o,
  input logic [LW-1:0] rx_level_o,
  input logic [4:0]    raw_irq_o,
  input logic [4:0]    masked_irq_o,
  input logic [4:0]    irq_mask_i,
  input logic          irq_o
);
  a_r2_level_bound: assert property (@(posedge clk_i) disable iff (!rst_ni)
    int'(tx_level_o) <= DEPTH && int'(rx_level_o) <= DEPTH);

  a_r4_thr_range: assert property (@(posedge clk_i) disable iff (!rst_ni)
    int'(tx_thr_o) < DEPTH);

  a_r7_tx_over: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_i && bus_wr_i && !ser_pop_i && int'(tx_level_o) == DEPTH)
    |=> (raw_irq_o[1] && int'(tx_level_o) == DEPTH));

  a_r8_rx_over: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_i && ser_push_i && !bus_rd_i && int'(rx_level_o) == DEPTH)
    |=> (raw_irq_o[3] && int'(rx_level_o) == DEPTH));

  a_r9_rx_under: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_i && bus_rd_i && rx_level_o == '0) |=> raw_irq_o[2]);

  a_r10_sticky: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (raw_irq_o[1] && !err_clr_i) |=> raw_irq_o[1]);

  a_r11_line: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o == |(raw_irq_o & irq_mask_i) && masked_irq_o == (raw_irq_o & irq_mask_i));

  a_r12_flush: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_i |=> (tx_level_o == '0 && rx_level_o == '0));
endmodule

bind fifo_irq_ctrl fifo_irq_ctrl_chk #(.DEPTH(DEPTH), .TW(TW)) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .en_i(en_i), .bus_wr_i(bus_wr_i),
  .bus_rd_i(bus_rd_i), .ser_pop_i(ser_pop_i), .ser_push_i(ser_push_i),
  .err_clr_i(err_clr_i), .tx_thr_o(tx_thr_o), .tx_level_o(tx_level_o),
  .rx_level_o(rx_level_o), .raw_irq_o(raw_irq_o), .masked_irq_o(masked_irq_o),
  .irq_mask_i(irq_mask_i), .irq_o(irq_o)
);

// File: tb/fifo_irq_ctrl_tb_top.sv
module fifo_irq_ctrl_tb_top;
  localparam int CLK_P = 10;
  localparam int DEPTH = 4;
  localparam int DW    = 8;
  localparam int TW    = 8;
  localparam int LW    = $clog2(DEPTH + 1);
  localparam int NV    = 19;

  logic clk_i = 1'b0, rst_ni = 1'b0, en_i = 1'b0;
  logic bus_wr_i = 0, bus_rd_i = 0, ser_pop_i = 0, ser_push_i = 0;
  logic [DW-1:0] bus_wdata_i = '0, ser_rx_data_i = '0;
  logic [DW-1:0] bus_rdata_o, ser_tx_data_o;
  logic ser_tx_valid_o;
  logic tx_thr_wr_i = 0, rx_thr_wr_i = 0;
  logic [TW-1:0] thr_wdata_i = '0, tx_thr_o, rx_thr_o;
  logic [4:0] irq_mask_i = '0, raw_irq_o, masked_irq_o;
  logic err_clr_i = 0, irq_o;
  logic [LW-1:0] tx_level_o, rx_level_o;

  int checks = 0, errors = 0;

  always #(CLK_P/2) clk_i = ~clk_i;

  fifo_irq_ctrl #(.DEPTH(DEPTH), .DW(DW), .TW(TW)) dut_i (.*);

  // {wr,rd,push,pop,chkd, data, exp_data, exp_tx_lvl, exp_rx_lvl, exp_raw}
  function automatic logic [33:0] mk(logic wr, logic rd, logic push, logic pop,
      logic chkd, logic [7:0] d, logic [7:0] ed, logic [3:0] tl, logic [3:0] rl,
      logic [4:0] raw);
    return {wr, rd, push, pop, chkd, d, ed, tl, rl, raw};
  endfunction

  localparam logic [33:0] VEC [NV] = '{
    mk(1,0,0,0,0,8'hA1,8'h00,1,0,5'b00000),
    mk(1,0,0,0,0,8'hA2,8'h00,2,0,5'b00000),
    mk(0,0,1,0,0,8'h51,8'h00,2,1,5'b10000),
    mk(1,0,0,0,0,8'hA3,8'h00,3,1,5'b10000),
    mk(0,0,1,0,0,8'h52,8'h00,3,2,5'b10000),
    mk(1,0,0,0,0,8'hA4,8'h00,4,2,5'b10000),
    mk(1,0,0,0,0,8'hA5,8'h00,4,2,5'b10010),
    mk(0,0,0,1,1,8'h00,8'hA1,3,2,5'b10010),
    mk(0,0,1,0,0,8'h53,8'h00,3,3,5'b10010),
    mk(0,0,1,0,0,8'h54,8'h00,3,4,5'b10010),
    mk(0,0,1,0,0,8'h55,8'h00,3,4,5'b11010),
    mk(0,1,0,0,1,8'h00,8'h51,3,3,5'b11010),
    mk(0,1,0,0,1,8'h00,8'h52,3,2,5'b11010),
    mk(0,1,0,0,1,8'h00,8'h53,3,1,5'b11010),
    mk(0,1,0,0,1,8'h00,8'h54,3,0,5'b01010),
    mk(0,1,0,0,0,8'h00,8'h00,3,0,5'b01110),
    mk(0,0,0,1,1,8'h00,8'hA2,2,0,5'b01110),
    mk(0,0,0,1,1,8'h00,8'hA3,1,0,5'b01110),
    mk(0,0,0,1,1,8'h00,8'hA4,0,0,5'b01111)
  };

  task automatic check(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  task automatic cyc();
    @(posedge clk_i);
    @(negedge clk_i);
    bus_wr_i = 0; bus_rd_i = 0; ser_push_i = 0; ser_pop_i = 0;
    tx_thr_wr_i = 0; rx_thr_wr_i = 0; err_clr_i = 0;
  endtask

  task automatic wr_thr(bit tx, int v);
    thr_wdata_i = TW'(v);
    if (tx) tx_thr_wr_i = 1; else rx_thr_wr_i = 1;
    cyc();
  endtask

  initial begin
    #(CLK_P * 20000);
    errors++;
    $display("FAIL watchdog actual=running expected=done");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (2) @(negedge clk_i);
    rst_ni = 1; en_i = 1;
    @(negedge clk_i);
    // R1 reset state
    check("R1 tx_level", int'(tx_level_o), 0);
    check("R1 rx_level", int'(rx_level_o), 0);
    check("R1 raw", int'(raw_irq_o), 5'b00001);
    check("R1 thr", int'(tx_thr_o) + int'(rx_thr_o), 0);
    check("R1 irq", int'(irq_o), 0);

    // table walk: R2 levels, R3 order, R5/R6 levels, R7/R8/R9 errors
    for (int i = 0; i < NV; i++) begin
      logic [33:0] v;
      v = VEC[i];
      bus_wr_i = v[33]; bus_rd_i = v[32]; ser_push_i = v[31]; ser_pop_i = v[30];
      bus_wdata_i = v[28:21]; ser_rx_data_i = v[28:21];
      #1;
      if (v[29] && v[32]) check("R3 rx order", int'(bus_rdata_o), int'(v[20:13]));
      if (v[29] && v[30]) check("R3 tx order", int'(ser_tx_data_o), int'(v[20:13]));
      cyc();
      check($sformatf("R2 tx_level v%0d", i), int'(tx_level_o), int'(v[12:9]));
      check($sformatf("R2 rx_level v%0d", i), int'(rx_level_o), int'(v[8:5]));
      check($sformatf("R7 R8 R9 raw v%0d", i), int'(raw_irq_o), int'(v[4:0]));
    end

    // R10 sticky across idle, then clear with a new underflow in the same cycle
    cyc();
    check("R10 sticky idle", int'(raw_irq_o), 5'b01111);
    bus_rd_i = 1; err_clr_i = 1;
    cyc();
    check("R10 clear vs new error", int'(raw_irq_o), 5'b00101);
    err_clr_i = 1;
    cyc();
    check("R10 clear", int'(raw_irq_o), 5'b00001);

    // R4 threshold range
    wr_thr(1, 3);
    check("R4 in range", int'(tx_thr_o), 3);
    wr_thr(1, DEPTH);
    check("R4 at depth", int'(tx_thr_o), 3);
    wr_thr(1, 9);
    check("R4 above depth", int'(tx_thr_o), 3);

    // R5 boundary: level 3 vs threshold 3
    for (int k = 0; k < 3; k++) begin
      bus_wr_i = 1; bus_wdata_i = DW'(k); cyc();
    end
    check("R5 level==thr", int'(raw_irq_o[0]), 1);
    bus_wr_i = 1; cyc();
    check("R5 level>thr", int'(raw_irq_o[0]), 0);

    // R6 boundary: threshold 2
    wr_thr(0, 2);
    for (int k = 0; k < 2; k++) begin
      ser_push_i = 1; cyc();
    end
    check("R6 level==thr", int'(raw_irq_o[4]), 0);
    ser_push_i = 1; cyc();
    check("R6 level==thr+1", int'(raw_irq_o[4]), 1);

    // R11 masking
    irq_mask_i = 5'b10000; #1;
    check("R11 masked", int'(masked_irq_o), 5'b10000);
    check("R11 irq on", int'(irq_o), 1);
    irq_mask_i = 5'b01111; #1;
    check("R11 masked off", int'(masked_irq_o), 0);
    check("R11 irq off", int'(irq_o), 0);

    // R7 write into full queue with a simultaneous pop
    bus_wr_i = 1; ser_pop_i = 1; cyc();
    check("R7 overflow flag", int'(raw_irq_o[1]), 1);
    check("R7 level after pop", int'(tx_level_o), 3);
    check("R11 irq via tx_over", int'(irq_o), 1);

    // R12 enable low flushes and ignores accesses
    en_i = 0; bus_wr_i = 1; ser_push_i = 1; bus_rd_i = 1;
    cyc();
    check("R12 tx flushed", int'(tx_level_o), 0);
    check("R12 rx flushed", int'(rx_level_o), 0);
    bus_rd_i = 1; cyc();
    check("R12 no error while off", int'(raw_irq_o), 5'b00011);
    en_i = 1; cyc();
    check("R12 thr kept", int'(tx_thr_o), 3);
    check("R12 rx thr kept", int'(rx_thr_o), 2);

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule